// File: doc/BRIEF.md
# Zoom and Pan Scan Address Generator

This block produces the linear pixel address that a display scan fetches, one pixel at a time, and supports hardware panning and integer zoom. The pan origin is the 20-bit linear address `y * line_width + x` of the pixel shown in the top-left corner. Software supplies it as a 16-bit upper part and a 4-bit lower part. A zoom factor of 1 to 16 repeats every source pixel and every source line. Two 4-bit offsets set where the scan starts inside the first zoomed pixel: one for the horizontal direction and one for the vertical direction. A stop value, counted in groups of four display lines, sets the display line at which the zoom ends and the scan goes back to 1:1.

Video timing drives the block with three single-cycle strobes: start of frame, end of a display line, and one pixel clock. The block updates `scan_addr` on the clock edge that follows each strobe. Memory access, timing generation and colour lookup are not part of this block.

Top module: `zp_scan_addr_gen`

## Requirements
- R1: On the edge after `frame_start`, `scan_addr` equals `{pan_word, pan_low}`, where `pan_word` gives bits 19:4 and `pan_low` gives bits 3:0.
- R2: The effective zoom `z` is `zoom_size_m1` while zoom is on, and 0 otherwise. While the block is inside a line, each source pixel is held for `z+1` pixel strobes. After that, `scan_addr` increases by one.
- R3: At the start of each frame and each line, the horizontal repeat count starts at `4*pixel_offset`. The first source pixel is therefore held for `max(1, z+1-4*pixel_offset)` strobes.
- R4: A `line_strobe` moves `scan_addr` back to the start of the current source line. After `z+1` display lines of the same source line, the start advances by one line width.
- R5: At frame start the vertical repeat count starts at `line_offset`. The first source line is therefore shown for `max(1, z+1-line_offset)` display lines.
- R6: The line width is 1152 when `res_sel`=0 and 1024 when `res_sel`=1.
- R7: Display lines are numbered from 0 at frame start. Lines with an index of at least `4*zoom_stop` run at 1:1. A `zoom_stop` of 0 therefore turns the zoom off for the whole frame.
- R8: Strobes have a fixed priority when they arrive in the same cycle: `frame_start` first, then `line_strobe`, then `pix_strobe`. A strobe of lower priority in the same cycle has no effect.
- R9: While `rst` is high at a clock edge, `scan_addr` is 0 on the next edge.
- R10: The address counts modulo 2^20, so advancing from 0xFFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Start-of-frame strobe |
| line_strobe | input | 1 | End-of-display-line strobe |
| pix_strobe | input | 1 | One display pixel consumed |
| res_sel | input | 1 | 0: 1152-pixel lines, 1: 1024-pixel lines |
| pan_word | input | 16 | Pan origin bits 19:4 |
| pan_low | input | 4 | Pan origin bits 3:0 |
| zoom_size_m1 | input | 4 | Zoomed pixel size minus one |
| line_offset | input | 4 | Starting vertical repeat count |
| pixel_offset | input | 4 | Starting horizontal repeat count, in units of 4 |
| zoom_stop | input | 9 | Display line where zoom ends, divided by 4 |
| scan_addr | output | 20 | Current pixel fetch address |

## Verification
A walked table runs full multi-line scans with several combinations of zoom, offsets, stop line and resolution. The combinations are chosen to separate the effects from each other:
- A 1:1 scan checks the plain address increment.
- Zooms of 2, 4 and 8 check the pixel and line repeat lengths.
- Offsets that are larger than the zoom check the clamp to a single repeat.
- A stop of one group checks that the zoom ends after line 3.
- The two resolutions check the line stride.

Directed cases add a hand-computed origin with both strides, the wrap at the top of the address space, and strobes that arrive together.

// File: rtl/zp_scan_pkg.sv
package zp_scan_pkg;

    localparam int ADDR_W  = 20;
    localparam int HI_W    = 16;
    localparam int LO_W    = ADDR_W - HI_W;
    localparam int ZOOM_W  = 4;
    localparam int STOP_W  = 9;
    localparam int LINE_W  = STOP_W + 2;
    localparam int REP_W   = ZOOM_W + 2;
    localparam int WIDE_PIX   = 1152;
    localparam int SQUARE_PIX = 1024;

    typedef logic [ADDR_W-1:0] pix_addr_t;

    typedef enum logic {
        RES_WIDE   = 1'b0,
        RES_SQUARE = 1'b1
    } res_mode_e;

    typedef struct packed {
        logic frame;
        logic line;
        logic pix;
    } scan_evt_t;

    function automatic pix_addr_t stride_of(input res_mode_e mode);
        return (mode == RES_SQUARE) ? pix_addr_t'(SQUARE_PIX) : pix_addr_t'(WIDE_PIX);
    endfunction

    function automatic pix_addr_t join_origin(input logic [HI_W-1:0] hi,
                                              input logic [LO_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/zp_repeat_ctr.sv
module zp_repeat_ctr #(
    parameter int CNT_W = 6,
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic [LIM_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_ext;

    assign lim_ext = CNT_W'(limit);
    assign done    = step && (cnt_q >= lim_ext);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step)
            cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    // R2/R3: a step either restarts the repeat count or adds one to it
    assert_rep_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

    // R3: a load sets the counter to the preload value on the next edge
    assert_rep_load_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/zp_addr_track.sv
module zp_addr_track
    import zp_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_load,
    input  pix_addr_t origin,
    input  logic      line_adv,
    input  logic      line_wrap,
    input  logic      pix_adv,
    input  pix_addr_t stride,
    output pix_addr_t addr
);

    pix_addr_t base_q;
    pix_addr_t addr_q;
    pix_addr_t base_nxt;

    always_comb begin
        base_nxt = base_q;
        if (line_wrap)
            base_nxt = base_q + stride;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
        end else if (frame_load) begin
            base_q <= origin;
            addr_q <= origin;
        end else if (line_adv) begin
            base_q <= base_nxt;
            addr_q <= base_nxt;
        end else if (pix_adv) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

    assert_frame_load_R1: assert property (@(posedge clk) disable iff (rst)
        frame_load |=> (addr == $past(origin)));

    assert_line_start_R4: assert property (@(posedge clk) disable iff (rst)
        (line_adv && !frame_load) |=>
            (addr == $past(base_q) || addr == $past(base_q) + $past(stride)));

    assert_pix_inc_R10: assert property (@(posedge clk) disable iff (rst)
        (pix_adv && !line_adv && !frame_load) |=> (addr == $past(addr) + 1'b1));

    assert_reset_zero_R9: assert property (@(posedge clk)
        rst |=> (addr == '0));

endmodule

// File: rtl/zp_scan_addr_gen.sv
module zp_scan_addr_gen
    import zp_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_strobe,
    input  logic              pix_strobe,
    input  logic              res_sel,
    input  logic [HI_W-1:0]   pan_word,
    input  logic [LO_W-1:0]   pan_low,
    input  logic [ZOOM_W-1:0] zoom_size_m1,
    input  logic [ZOOM_W-1:0] line_offset,
    input  logic [ZOOM_W-1:0] pixel_offset,
    input  logic [STOP_W-1:0] zoom_stop,
    output logic [ADDR_W-1:0] scan_addr
);

    scan_evt_t           evt;
    logic [LINE_W-1:0]   line_idx_q;
    logic                zoom_on;
    logic [ZOOM_W-1:0]   zoom_eff;
    logic                h_done;
    logic                v_done;
    logic                pix_adv;
    logic                line_adv;
    logic [REP_W-1:0]    h_preload;
    logic [REP_W-1:0]    v_preload;
    pix_addr_t           origin;
    pix_addr_t           stride;

    // frame beats line beats pixel
    always_comb begin
        evt.frame = frame_start;
        evt.line  = line_strobe && !frame_start;
        evt.pix   = pix_strobe && !line_strobe && !frame_start;
    end

    assign zoom_on   = line_idx_q < {zoom_stop, 2'b00};
    assign zoom_eff  = zoom_on ? zoom_size_m1 : '0;
    assign h_preload = {pixel_offset, 2'b00};
    assign v_preload = REP_W'(line_offset);
    assign origin    = join_origin(pan_word, pan_low);
    assign stride    = stride_of(res_mode_e'(res_sel));

    always_ff @(posedge clk) begin
        if (rst)
            line_idx_q <= '0;
        else if (evt.frame)
            line_idx_q <= '0;
        else if (evt.line && line_idx_q != '1)
            line_idx_q <= line_idx_q + 1'b1;
    end

    zp_repeat_ctr #(.CNT_W(REP_W), .LIM_W(ZOOM_W)) u_hrep (
        .clk      (clk),
        .rst      (rst),
        .load     (evt.frame || evt.line),
        .load_val (h_preload),
        .step     (evt.pix),
        .limit    (zoom_eff),
        .done     (h_done)
    );

    zp_repeat_ctr #(.CNT_W(REP_W), .LIM_W(ZOOM_W)) u_vrep (
        .clk      (clk),
        .rst      (rst),
        .load     (evt.frame),
        .load_val (v_preload),
        .step     (evt.line),
        .limit    (zoom_eff),
        .done     (v_done)
    );

    assign pix_adv  = h_done;
    assign line_adv = evt.line;

    zp_addr_track u_track (
        .clk        (clk),
        .rst        (rst),
        .frame_load (evt.frame),
        .origin     (origin),
        .line_adv   (line_adv),
        .line_wrap  (v_done),
        .pix_adv    (pix_adv),
        .stride     (stride),
        .addr       (scan_addr)
    );

    // R7: past the stop line every lone pixel strobe advances the address
    assert_zoom_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!zoom_on && pix_strobe && !line_strobe && !frame_start)
            |=> (scan_addr == $past(scan_addr) + 1'b1));

    // R8: a pixel strobe that shares a cycle with a line strobe adds nothing
    assert_line_over_pix_R8: assert property (@(posedge clk) disable iff (rst)
        (line_strobe && !frame_start) |=>
            (scan_addr == $past(u_track.base_q) ||
             scan_addr == $past(u_track.base_q) + $past(stride)));

    assert_onehot_evt_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.frame, evt.line, evt.pix}));

endmodule

// File: tb/test_zp_scan_addr_gen.sv
module test_zp_scan_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start, line_strobe, pix_strobe, res_sel;
    logic [15:0] pan_word;
    logic [3:0]  pan_low, zoom_size_m1, line_offset, pixel_offset;
    logic [8:0]  zoom_stop;
    logic [19:0] scan_addr;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    // model state
    int m_base, m_addr, m_h, m_v, m_line;

    always #5 clk = ~clk;

    zp_scan_addr_gen i_zp_scan_addr_gen (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_strobe(line_strobe),
        .pix_strobe(pix_strobe), .res_sel(res_sel), .pan_word(pan_word),
        .pan_low(pan_low), .zoom_size_m1(zoom_size_m1), .line_offset(line_offset),
        .pixel_offset(pixel_offset), .zoom_stop(zoom_stop), .scan_addr(scan_addr)
    );

    // {zoom[21:18], pixoff[17:14], lineoff[13:10], zstop[9:1], res[0]}
    localparam logic [21:0] CFG [0:5] = '{
        {4'd0, 4'd0, 4'd0, 9'd0,  1'b0},
        {4'd1, 4'd0, 4'd0, 9'd64, 1'b0},
        {4'd3, 4'd0, 4'd2, 9'd64, 1'b1},
        {4'd7, 4'd1, 4'd0, 9'd64, 1'b0},
        {4'd3, 4'd3, 4'd5, 9'd1,  1'b1},
        {4'd2, 4'd0, 4'd0, 9'd1,  1'b0}
    };

    task automatic check(input string tag, input logic [19:0] exp);
        checks++;
        if (scan_addr !== exp) begin
            failures++;
            $display("FAIL %s: scan_addr=%h expected=%h", tag, scan_addr, exp);
        end
    endtask

    function automatic int zeff();
        return (m_line < zoom_stop * 4) ? int'(zoom_size_m1) : 0;
    endfunction

    function automatic int width();
        return res_sel ? 1024 : 1152;
    endfunction

    // model of the requirements: kind 0 frame, 1 line, 2 pixel
    task automatic model(input int kind);
        int z;
        z = zeff();
        if (kind == 0) begin
            m_base = {pan_word, pan_low};
            m_addr = m_base; m_h = 4 * pixel_offset; m_v = line_offset; m_line = 0;
        end else if (kind == 1) begin
            if (m_v >= z) begin m_base = (m_base + width()) % (1 << 20); m_v = 0; end
            else m_v++;
            m_line++;
            m_addr = m_base; m_h = 4 * pixel_offset;
        end else begin
            if (m_h >= z) begin m_addr = (m_addr + 1) % (1 << 20); m_h = 0; end
            else m_h++;
        end
    endtask

    task automatic strobe(input logic f, input logic l, input logic p);
        @(negedge clk);
        frame_start = f; line_strobe = l; pix_strobe = p;
        @(posedge clk);
        #1;
        frame_start = 1'b0; line_strobe = 1'b0; pix_strobe = 1'b0;
    endtask

    task automatic step_model(input int kind, input string tag);
        strobe(kind == 0, kind == 1, kind == 2);
        model(kind);
        check(tag, 20'(m_addr));
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_start = 0; line_strobe = 0; pix_strobe = 0;
        res_sel = 0; pan_word = 16'h00D8; pan_low = 4'd5;
        zoom_size_m1 = 0; line_offset = 0; pixel_offset = 0; zoom_stop = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", 20'd0);
        @(negedge clk); rst = 1'b0;

        // R1 / R6: origin y=3, x=5 at 1152 -> 3461, next line 4613
        strobe(1, 0, 0); check("R1 origin load", 20'd3461);
        strobe(0, 1, 0); check("R6 stride 1152", 20'd4613);
        res_sel = 1;
        strobe(1, 0, 0); check("R1 origin reload", 20'd3461);
        strobe(0, 1, 0); check("R6 stride 1024", 20'd4485);

        // R8 priority
        strobe(1, 1, 1); check("R8 frame wins", 20'd3461);
        strobe(0, 0, 1); check("R8 pixel alone", 20'd3462);
        strobe(0, 1, 1); check("R8 line beats pixel", 20'd4485);

        // R10 wrap
        pan_word = 16'hFFFF; pan_low = 4'hF;
        strobe(1, 0, 0); check("R10 top address", 20'hFFFFF);
        strobe(0, 0, 1); check("R10 wrap to zero", 20'd0);

        // R3 hand case: zoom 8, pixel offset 1 -> first pixel held 4 strobes
        pan_word = 16'h0010; pan_low = 4'h0; zoom_size_m1 = 4'd7;
        pixel_offset = 4'd1; zoom_stop = 9'd64;
        strobe(1, 0, 0);
        for (int i = 0; i < 3; i++) begin
            strobe(0, 0, 1); check("R3 first pixel held", 20'h100);
        end
        strobe(0, 0, 1); check("R3 first pixel advance", 20'h101);

        // R7: stop 0 disables zoom entirely
        zoom_stop = 9'd0; pixel_offset = 0;
        strobe(1, 0, 0);
        strobe(0, 0, 1); check("R7 no zoom when stop is zero", 20'h101);

        // table of scan configurations: R2 R3 R4 R5 R6 R7
        for (int c = 0; c < 6; c++) begin
            zoom_size_m1 = CFG[c][21:18];
            pixel_offset = CFG[c][17:14];
            line_offset  = CFG[c][13:10];
            zoom_stop    = CFG[c][9:1];
            res_sel      = CFG[c][0];
            pan_word     = 16'h1234 + 16'(c * 16'h0111);
            pan_low      = 4'(c);
            step_model(0, "R1 table frame");
            for (int ln = 0; ln < 7; ln++) begin
                for (int px = 0; px < 12; px++)
                    step_model(2, "R2 R3 R7 table pixel");
                step_model(1, "R4 R5 R6 R7 table line");
            end
        end

        // R9 reset mid-scan
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R9 reset mid scan", 20'd0);
        rst = 1'b0;

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule